// File: doc/BRIEF.md
# Hard-Decision Bit-Flipping Parity-Check Decoder

This block accepts one received hard-decision word and repairs it with an iterative bit-flipping loop. It first evaluates every parity check of the parity-check matrix against the current word. A check fails when the word, masked by that check's row, has odd parity. When one or more checks fail, each bit is scored by how many failing checks include it. Every bit that shares the highest score is inverted, and the checks are evaluated again. One iteration takes one clock cycle. The loop stops as soon as all checks pass, or after a fixed iteration budget. In the second case the word is reported as uncorrectable.

The matrix is a parameter. Its default has five checks over ten bits. Each column names a distinct pair of checks, so every column holds two ones and every row holds four. This makes the syndrome of any single-bit error unique and aimed at exactly one bit. A column weight of two forces the rows to sum to zero, so the default matrix has rank four and accepts 64 words. The encoder uses a 5-bit-message subset of them. The message is read from the top K bits of the result. A one-cycle result strobe carries the result word, the message field, a flag saying the input already passed every check, and the uncorrectable flag.

Top module: `ldpc_bf_decoder`

## Requirements
- R1: While reset is held and after it is released, out_valid is 0 and out_word, out_msg, out_clean and out_uncorr are all 0 until the first result.
- R2: Check r fails when the XOR of (word AND row r of H_ROWS) is 1. An input that fails no check is returned unchanged with out_clean=1 and out_uncorr=0. Its out_valid pulse comes on the 2nd rising edge, counting the edge that captured the input as the 1st.
- R3: The default H_ROWS has these rows, with bit j as column j: row0=10'h00F, row1=10'h071, row2=10'h192, row3=10'h2A4, row4=10'h348. Column j covers the j-th pair (a,b), a<b, of rows in lexicographic order. For every word that fails no check, inverting any single bit gives a result equal to the original word, with out_clean=0 and out_uncorr=0.
- R4: Each iteration inverts every bit whose count of failing checks equals the largest nonzero count, and takes one clock. An input needing one iteration produces its pulse on the 3rd edge.
- R5: out_msg equals out_word[N-1:N-K], which is bits 9..5 by default.
- R6: If checks still fail after MAX_ITER iterations (default 8), out_uncorr=1 and out_clean=0. out_word is the word reached after the last iteration, and the pulse comes on edge MAX_ITER+2.
- R7: out_valid is a one-cycle pulse, exactly one per accepted input. Between pulses out_word and the flags hold their values.
- R8: in_valid is ignored while a decode is in progress. Neither the result nor the pulse count is affected.
- R9: Whenever out_uncorr=0 at a pulse, out_word fails no check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received word present; taken only when idle |
| in_word | input | N | Received hard-decision word |
| out_valid | output | 1 | One-cycle result strobe |
| out_word | output | N | Corrected (or last reached) word |
| out_msg | output | K | Message field of out_word |
| out_clean | output | 1 | Input failed no check |
| out_uncorr | output | 1 | Iteration budget exhausted with checks still failing |

## Verification
With the default matrix, every syndrome of weight two or four clears after a single iteration. The uncorrectable exit can therefore never be reached through the default instance's ports. The bench adds a second instance with a small irregular matrix and a budget of three. In that instance one check covers two bits and nothing else separates them, so the word swaps between two states forever. This drives the budget exit and checks which word is reported. The single-error sweep reaches every pair-shaped syndrome by enumerating all 64 accepted words and inverting each bit in turn.

// File: rtl/ldpc_bf_pkg.sv
package ldpc_bf_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dec_state_e;
endpackage

// File: rtl/ldpc_bf_syndrome.sv
module ldpc_bf_syndrome #(
   parameter int N = 10,
   parameter int M = 5,
   parameter logic [M-1:0][N-1:0] H_ROWS = '0
) (
   input  logic [N-1:0] word,
   output logic [M-1:0] syn
);
   for (genvar r = 0; r < M; r++) begin : g_row
      assign syn[r] = ^(word & H_ROWS[r]);
   end
endmodule

// File: rtl/ldpc_bf_flip.sv
module ldpc_bf_flip #(
   parameter int N = 10,
   parameter int M = 5,
   parameter logic [M-1:0][N-1:0] H_ROWS = '0
) (
   input  logic [M-1:0] syn,
   output logic [N-1:0] flip_mask
);
   localparam int CNT_W = $clog2(M + 1);

   logic [N-1:0][CNT_W-1:0] score;
   logic [CNT_W-1:0]        top_score;

   for (genvar j = 0; j < N; j++) begin : g_score
      always_comb begin
         score[j] = '0;
         for (int r = 0; r < M; r++) begin
            score[j] = score[j] + CNT_W'(H_ROWS[r][j] & syn[r]);
         end
      end
   end

   always_comb begin
      top_score = '0;
      for (int j = 0; j < N; j++) begin
         if (score[j] > top_score) top_score = score[j];
      end
   end

   for (genvar j = 0; j < N; j++) begin : g_mask
      assign flip_mask[j] = (top_score != '0) && (score[j] == top_score);
   end
endmodule

// File: rtl/ldpc_bf_ctrl.sv
module ldpc_bf_ctrl
   import ldpc_bf_pkg::*;
#(
   parameter int MAX_ITER = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  logic syn_zero,
   output logic accept,
   output logic flip_en,
   output logic finish,
   output logic give_up,
   output logic first_pass
);
   localparam int ITER_W = $clog2(MAX_ITER + 1);
   localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(MAX_ITER);

   dec_state_e        state;
   logic [ITER_W-1:0] iter;
   logic              running;
   logic              at_limit;

   assign running    = (state == ST_RUN);
   assign at_limit   = (iter == ITER_LAST);
   assign accept     = in_valid && (state == ST_IDLE);
   assign finish     = running && (syn_zero || at_limit);
   assign give_up    = running && !syn_zero && at_limit;
   assign flip_en    = running && !syn_zero && !at_limit;
   assign first_pass = (iter == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         iter  <= '0;
      end else if (accept) begin
         state <= ST_RUN;
         iter  <= '0;
      end else if (finish) begin
         state <= ST_IDLE;
      end else if (flip_en) begin
         iter <= iter + 1'b1;
      end
   end
endmodule

// File: rtl/ldpc_bf_decoder.sv
module ldpc_bf_decoder #(
   parameter int N        = 10,
   parameter int M        = 5,
   parameter int K        = 5,
   parameter int MAX_ITER = 8,
   parameter logic [M-1:0][N-1:0] H_ROWS =
      {10'h348, 10'h2A4, 10'h192, 10'h071, 10'h00F}
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [N-1:0] in_word,
   output logic         out_valid,
   output logic [N-1:0] out_word,
   output logic [K-1:0] out_msg,
   output logic         out_clean,
   output logic         out_uncorr
);
   if (K < 1 || K > N) begin : g_bad_k
      $error("K must lie in 1..N");
   end
   if (M < 1 || M >= N) begin : g_bad_m
      $error("M must lie in 1..N-1");
   end
   if (MAX_ITER < 1) begin : g_bad_iter
      $error("MAX_ITER must be at least 1");
   end

   logic [N-1:0] cur_word;
   logic [M-1:0] cur_syn;
   logic [N-1:0] flip_mask;
   logic         syn_zero;
   logic         accept, flip_en, finish, give_up, first_pass;

   assign syn_zero = (cur_syn == '0);

   ldpc_bf_syndrome #(.N(N), .M(M), .H_ROWS(H_ROWS)) u_syn (
      .word (cur_word),
      .syn  (cur_syn)
   );

   ldpc_bf_flip #(.N(N), .M(M), .H_ROWS(H_ROWS)) u_flip (
      .syn       (cur_syn),
      .flip_mask (flip_mask)
   );

   ldpc_bf_ctrl #(.MAX_ITER(MAX_ITER)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .syn_zero   (syn_zero),
      .accept     (accept),
      .flip_en    (flip_en),
      .finish     (finish),
      .give_up    (give_up),
      .first_pass (first_pass)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_word <= '0;
      end else if (accept) begin
         cur_word <= in_word;
      end else if (flip_en) begin
         cur_word <= cur_word ^ flip_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_word   <= '0;
         out_msg    <= '0;
         out_clean  <= 1'b0;
         out_uncorr <= 1'b0;
      end else begin
         out_valid <= finish;
         if (finish) begin
            out_word   <= cur_word;
            out_msg    <= cur_word[N-1 -: K];
            out_clean  <= syn_zero && first_pass;
            out_uncorr <= give_up;
         end
      end
   end
endmodule

// File: rtl/ldpc_bf_decoder_chk.sv
module ldpc_bf_decoder_chk #(
   parameter int N        = 10,
   parameter int M        = 5,
   parameter int K        = 5,
   parameter int MAX_ITER = 8,
   parameter logic [M-1:0][N-1:0] H_ROWS = '0
) (
   input logic         clk,
   input logic         rst,
   input logic         accept,
   input logic [N-1:0] in_word,
   input logic         out_valid,
   input logic [N-1:0] out_word,
   input logic [K-1:0] out_msg,
   input logic         out_clean,
   input logic         out_uncorr
);
   localparam int LAT_W = $clog2(MAX_ITER + 3);

   logic [N-1:0] last_in;
   logic         pend;
   logic [LAT_W-1:0] age;
   logic [M-1:0] out_syn;

   always_comb begin
      for (int r = 0; r < M; r++) out_syn[r] = ^(out_word & H_ROWS[r]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         last_in <= '0;
         pend    <= 1'b0;
         age     <= '0;
      end else if (accept) begin
         last_in <= in_word;
         pend    <= 1'b1;
         age     <= '0;
      end else if (out_valid) begin
         pend <= 1'b0;
      end else if (pend) begin
         age <= age + 1'b1;
      end
   end

   AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_clean |-> out_word == last_in);                    // R2
   AST_SYN_CLEARED: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_uncorr |-> out_syn == '0);                        // R9
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);                                          // R7
   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_word) && $stable(out_uncorr));           // R7
   AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !(out_clean && out_uncorr));                          // R6
   AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst)
      pend |-> age <= LAT_W'(MAX_ITER + 1));                              // R6
   AST_MSG_FIELD: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_msg == out_word[N-1 -: K]);                       // R5
   AST_PULSE_OWNED: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !$past(out_valid));                                   // R7
endmodule

bind ldpc_bf_decoder ldpc_bf_decoder_chk #(
   .N(N), .M(M), .K(K), .MAX_ITER(MAX_ITER), .H_ROWS(H_ROWS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .accept     (accept),
   .in_word    (in_word),
   .out_valid  (out_valid),
   .out_word   (out_word),
   .out_msg    (out_msg),
   .out_clean  (out_clean),
   .out_uncorr (out_uncorr)
);

// File: tb/ldpc_bf_decoder_bench.sv
module ldpc_bf_decoder_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [9:0] in_word = '0;
   logic       out_valid;
   logic [9:0] out_word;
   logic [4:0] out_msg;
   logic       out_clean, out_uncorr;

   logic       o_in_valid = 1'b0;
   logic [2:0] o_in_word = '0;
   logic       o_out_valid;
   logic [2:0] o_out_word;
   logic [0:0] o_out_msg;
   logic       o_out_clean, o_out_uncorr;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldpc_bf_decoder u_ldpc_bf_decoder (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_word(out_word), .out_msg(out_msg),
      .out_clean(out_clean), .out_uncorr(out_uncorr)
   );

   // single check covers bits 0 and 1 only: an error there swaps forever
   ldpc_bf_decoder #(
      .N(3), .M(2), .K(1), .MAX_ITER(3), .H_ROWS({3'b100, 3'b011})
   ) u_ldpc_bf_decoder_osc (
      .clk(clk), .rst(rst), .in_valid(o_in_valid), .in_word(o_in_word),
      .out_valid(o_out_valid), .out_word(o_out_word), .out_msg(o_out_msg),
      .out_clean(o_out_clean), .out_uncorr(o_out_uncorr)
   );

   int pa[10];
   int pb[10];
   logic [9:0] cw[64];
   int n_cw;

   logic [9:0] r_word;
   logic [4:0] r_msg;
   logic       r_clean, r_unc;
   int         r_lat, r_extra;

   function automatic logic [4:0] bench_syn(input logic [9:0] w);
      logic [4:0] s = '0;
      for (int j = 0; j < 10; j++) begin
         if (w[j]) begin
            s[pa[j]] = ~s[pa[j]];
            s[pb[j]] = ~s[pb[j]];
         end
      end
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_dec(input logic [9:0] w, input int extra);
      int n = 0;
      bit got = 0;
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      @(posedge clk);
      r_lat = 0;
      while (!got && n < 40) begin
         @(negedge clk);
         n++;
         if (n > extra) in_valid = 1'b0;
         else in_word = w ^ 10'h3FF;
         if (out_valid) begin
            got = 1;
            r_lat = n;
            r_word = out_word; r_msg = out_msg;
            r_clean = out_clean; r_unc = out_uncorr;
         end
      end
      in_valid = 1'b0;
      r_extra = 0;
      repeat (3) begin
         @(negedge clk);
         if (out_valid) r_extra++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int j = 0;
      void'($urandom(32'd4021));
      for (int a = 0; a < 5; a++)
         for (int b = a + 1; b < 5; b++) begin
            pa[j] = a; pb[j] = b; j++;
         end
      n_cw = 0;
      for (int w = 0; w < 1024; w++)
         if (bench_syn(10'(w)) == '0) begin
            cw[n_cw] = 10'(w); n_cw++;
         end
      chk(n_cw == 64, "R3", "codeword count", n_cw, 64);

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 0 && out_word == 0 && out_msg == 0 && !out_clean && !out_uncorr,
          "R1", "outputs in reset", {out_valid, out_word}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(out_valid == 0 && out_word == 0, "R1", "outputs after reset",
          {out_valid, out_word}, 0);

      // R2 / R5: every accepted word passes untouched
      for (int c = 0; c < 64; c++) begin
         run_dec(cw[c], 0);
         chk(r_word == cw[c], "R2", "clean word", r_word, cw[c]);
         chk(r_clean && !r_unc, "R2", "clean flags", {r_clean, r_unc}, 2);
         chk(r_lat == 2, "R2", "clean latency", r_lat, 2);
         chk(r_msg == cw[c][9:5], "R5", "message field", r_msg, cw[c][9:5]);
         chk(r_extra == 0, "R7", "extra pulses", r_extra, 0);
      end

      // R3 / R4: every single-bit error
      for (int c = 0; c < 64; c++)
         for (int b = 0; b < 10; b++) begin
            run_dec(cw[c] ^ (10'd1 << b), 0);
            chk(r_word == cw[c], "R3", "single error fixed", r_word, cw[c]);
            chk(!r_clean && !r_unc, "R3", "single error flags", {r_clean, r_unc}, 0);
            chk(r_lat == 3, "R4", "one iteration latency", r_lat, 3);
         end

      // R8: input strobe held with other data while busy
      run_dec(cw[37] ^ 10'h040, 2);
      chk(r_word == cw[37], "R8", "busy input ignored", r_word, cw[37]);
      chk(r_extra == 0, "R8", "no extra result", r_extra, 0);

      // random multi-bit patterns; syndromes of weight 2 or 4 clear in one pass
      for (int t = 0; t < 300; t++) begin
         logic [9:0] w = 10'($urandom);
         run_dec(w, 0);
         if (bench_syn(w) == '0) begin
            chk(r_word == w && r_clean && r_lat == 2, "R2", "random clean", r_word, w);
         end else begin
            chk(!r_unc && !r_clean, "R9", "random flags", {r_clean, r_unc}, 0);
            chk(bench_syn(r_word) == '0, "R9", "random result checks", bench_syn(r_word), 0);
            chk(r_lat == 3, "R4", "random latency", r_lat, 3);
            chk(r_msg == r_word[9:5], "R5", "random message", r_msg, r_word[9:5]);
         end
      end

      // R6: oscillating instance, budget of 3
      begin
         int n = 0;
         bit got = 0;
         @(negedge clk);
         o_in_valid = 1'b1; o_in_word = 3'b001;
         @(negedge clk);
         o_in_valid = 1'b0;
         n = 1;
         while (!got && n < 40) begin
            if (o_out_valid) got = 1;
            else begin @(negedge clk); n++; end
         end
         chk(n == 5, "R6", "budget latency", n, 5);
         chk(o_out_uncorr && !o_out_clean, "R6", "uncorrectable flags",
             {o_out_uncorr, o_out_clean}, 2);
         chk(o_out_word == 3'b010, "R6", "last word reached", o_out_word, 3'b010);
         chk(o_out_msg == 1'b0, "R5", "osc message", o_out_msg, 0);
      end
      begin
         int n = 0;
         bit got = 0;
         @(negedge clk);
         o_in_valid = 1'b1; o_in_word = 3'b100;
         @(negedge clk);
         o_in_valid = 1'b0;
         n = 1;
         while (!got && n < 40) begin
            if (o_out_valid) got = 1;
            else begin @(negedge clk); n++; end
         end
         chk(n == 3 && o_out_word == 3'b000 && !o_out_uncorr, "R4",
             "lone top-score bit", o_out_word, 3'b000);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule